// File: doc/BRIEF.md
# Write-only serial clock-control slave

This block is a two-wire serial slave that only accepts block writes. A host starts a transfer and sends the device address byte. It then sends a command byte and a count byte, and both are acknowledged and discarded. The data bytes that follow are stored in a small register bank, always starting at register 0 and moving up one register per byte. The block cannot be read and has no sub-addressing. To change a later register, the host must resend every register in front of it.

The serial clock and data lines are sampled by a faster system clock. Each line passes through a two-flop synchronizer and a stability filter before any edge decision is made. The acknowledge is driven by raising an open-drain pull-low enable, never by driving the line high.

Register 0 holds a run/stop bit for each of eight clock outputs. All outputs are gated from one source clock by a scheme that never cuts a pulse short. Register contents return to their defaults only on the true power-on reset. The power-down input stops all clock outputs and aborts any transfer, but it leaves the registers untouched.

Top module: `smb_clkctl_slave`

## Requirements
- R1: After power-on reset, register 0 reads 0xFF, registers 1 to 9 read 0x00 and `sda_oe` is low. From the first falling edge of `ref_clk` after reset, every bit of `clk_o` follows `ref_clk`.
- R2: A falling `sda_i` while `scl_i` is high is a start condition. It restarts address reception from any state, including a repeated start in the middle of a transfer, and the data bytes after it fill the registers again from register 0.
- R3: The first byte after a start is acknowledged only when it equals 0xD2 (7-bit address 0x69 in bits 7..1, write flag 0 in bit 0). Any other value, including 0xD3 (a read), gets no acknowledge for it or for any later byte of the transfer, and no register changes.
- R4: After an acknowledged address, the next two bytes (command and count) are acknowledged and change no register. `sda_oe` only ever rises while the filtered serial clock is low.
- R5: Bytes are shifted in most significant bit first. The k-th data byte after the two header bytes (k counted from 0) is acknowledged and written to register k.
- R6: A rising `sda_i` while `scl_i` is high is a stop condition. It releases `sda_oe` and returns the slave to idle, so bytes sent before the next start get no acknowledge.
- R7: At most 10 data bytes are accepted per transfer. The 11th and every later data byte of the same transfer get no acknowledge and change no register.
- R8: While `pwrdn` is high, every bit of `clk_o` is held low, the transfer in progress is abandoned with `sda_oe` released, and no register changes. After `pwrdn` falls, the slave waits for a new start.
- R9: Bit k of register 0 (k = 0..7) enables `clk_o[k]`: 1 lets it run and 0 holds it low. Outputs only change on `ref_clk` edges, so no pulse is ever shortened.
- R10: A pulse on `scl_i` or `sda_i` shorter than FILT_LEN (4) system clock cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial lines |
| por_n | input | 1 | True power-on reset, active low, asynchronous |
| pwrdn | input | 1 | Power-down: stops the clock outputs and aborts the transfer |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| ref_clk | input | 1 | Source clock for the gated outputs |
| clk_o | output | 8 | Gated clock outputs |
| reg_bank | output | 80 | Register bank, register k in bits 8k+7..8k |

## Verification
Two functions can land in the same cycle. A register write can coincide with a bus abort, either from a repeated start right after an acknowledged data byte or from power-down raised in the middle of the following byte. The bench provokes both cases. It then judges them by the acknowledge it sees in every slot and by the register bank read at the ports: the write before the abort must stand, nothing after it may land, and the next transfer must fill from register 0. A second overlap is a serial clock glitch during a data bit, which must neither add a bit nor disturb the write that ends that byte.

// File: rtl/smbc_pkg.sv
package smbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_ACK   = 2'd2,
    ST_SKIP  = 2'd3
  } smb_state_e;

  // bytes between start and first data byte: address, command, count
  localparam int HDR_BYTES = 3;

  function automatic logic [7:0] addr_byte(input logic [6:0] dev_addr);
    return {dev_addr, 1'b0};
  endfunction

  // decides whether the byte at position idx of a transfer earns an acknowledge
  function automatic logic byte_take(input int idx, input logic [7:0] b,
                                     input logic [6:0] dev_addr, input int nreg);
    if (idx == 0) return (b == addr_byte(dev_addr));
    return (idx < HDR_BYTES + nreg);
  endfunction

  function automatic int next_idx(input int idx, input int lim);
    return (idx >= lim) ? lim : idx + 1;
  endfunction

  function automatic logic [7:0] reg_default(input int i);
    return (i == 0) ? 8'hFF : 8'h00;
  endfunction

endpackage

// File: rtl/smbc_line_filt.sv
module smbc_line_filt #(
  parameter int SYNC     = 2,
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]   cnt;
  logic            samp;

  assign samp = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], line_i};
  end

  // output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      line_o <= 1'b1;
      cnt    <= '0;
    end else if (samp == line_o) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_LEN - 1)) begin
      line_o <= samp;
      cnt    <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/smbc_proto.sv
module smbc_proto
  import smbc_pkg::*;
#(
  parameter int         NREG     = 10,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         IDXW     = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            pwrdn,
  input  logic            scl_f,
  input  logic            sda_f,
  output logic            sda_oe,
  output logic            start_ev,
  output logic            stop_ev,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data
);
  localparam int IDX_LIM = HDR_BYTES + NREG;

  logic            scl_q, sda_q;
  logic            scl_rise, scl_fall;
  smb_state_e      state;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic [IDXW-1:0] idx;
  logic            byte_done, take;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  assign byte_done = (state == ST_SHIFT) && scl_fall && (bitcnt == 4'd8);
  assign take      = byte_take(int'(idx), shreg, DEV_ADDR, NREG);
  assign wr_en     = byte_done & take & (int'(idx) >= HDR_BYTES) & ~pwrdn;
  assign wr_idx    = idx - IDXW'(HDR_BYTES);
  assign wr_data   = shreg;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
      idx    <= '0;
    end else if (pwrdn) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      bitcnt <= '0;
      idx    <= '0;
    end else if (start_ev) begin
      state  <= ST_SHIFT;
      sda_oe <= 1'b0;
      bitcnt <= '0;
      idx    <= '0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_SHIFT: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_done) begin
            if (take) begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            idx    <= IDXW'(next_idx(int'(idx), IDX_LIM));
            state  <= ST_SHIFT;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smbc_regbank.sv
module smbc_regbank
  import smbc_pkg::*;
#(
  parameter int NREG = 10,
  parameter int IDXW = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] bank
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [7:0] r;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                          r <= reg_default(i);
      else if (wr_en && wr_idx == IDXW'(i)) r <= wr_data;
    end
    assign bank[i*8 +: 8] = r;
  end
endmodule

// File: rtl/smbc_clkgate.sv
module smbc_clkgate #(
  parameter int NOUT = 8
) (
  input  logic            ref_clk,
  input  logic            por_n,
  input  logic            pwrdn,
  input  logic [NOUT-1:0] en,
  output logic [NOUT-1:0] clk_o
);
  for (genvar k = 0; k < NOUT; k++) begin : g_gate
    logic en_q;
    // enable captured while the source clock is low
    always_ff @(negedge ref_clk or negedge por_n) begin
      if (!por_n) en_q <= 1'b0;
      else        en_q <= en[k] & ~pwrdn;
    end
    assign clk_o[k] = ref_clk & en_q;
  end
endmodule

// File: rtl/smb_clkctl_slave.sv
module smb_clkctl_slave
  import smbc_pkg::*;
#(
  parameter int         NREG     = 10,
  parameter int         NOUT     = 8,
  parameter int         FILT_LEN = 4,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pwrdn,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              ref_clk,
  output logic [NOUT-1:0]   clk_o,
  output logic [NREG*8-1:0] reg_bank
);
  localparam int IDXW = $clog2(HDR_BYTES + NREG + 1);

  logic            scl_f, sda_f;
  logic            start_ev, stop_ev;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [7:0]      wr_data;

  smbc_line_filt #(.SYNC(2), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .por_n(por_n), .line_i(scl_i), .line_o(scl_f));

  smbc_line_filt #(.SYNC(2), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .por_n(por_n), .line_i(sda_i), .line_o(sda_f));

  smbc_proto #(.NREG(NREG), .DEV_ADDR(DEV_ADDR), .IDXW(IDXW)) u_proto (
    .clk(clk), .por_n(por_n), .pwrdn(pwrdn), .scl_f(scl_f), .sda_f(sda_f),
    .sda_oe(sda_oe), .start_ev(start_ev), .stop_ev(stop_ev),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  smbc_regbank #(.NREG(NREG), .IDXW(IDXW)) u_regs (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .bank(reg_bank));

  smbc_clkgate #(.NOUT(NOUT)) u_gate (
    .ref_clk(ref_clk), .por_n(por_n), .pwrdn(pwrdn),
    .en(reg_bank[NOUT-1:0]), .clk_o(clk_o));
endmodule

// File: rtl/smb_clkctl_slave_chk.sv
module smb_clkctl_slave_chk #(
  parameter int NREG = 10,
  parameter int IDXW = 4
) (
  input logic              clk,
  input logic              por_n,
  input logic              pwrdn,
  input logic              scl_f,
  input logic              sda_oe,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              wr_en,
  input logic [IDXW-1:0]   wr_idx,
  input logic [NREG*8-1:0] reg_bank
);
  // R4: acknowledge is only raised in the low phase of the serial clock
  a_r4_ack_low_phase: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sda_oe) |-> !scl_f);

  // R2: a start condition releases the data line
  a_r2_start_releases: assert property (@(posedge clk) disable iff (!por_n)
    start_ev |=> !sda_oe);

  // R6: a stop condition releases the data line
  a_r6_stop_releases: assert property (@(posedge clk) disable iff (!por_n)
    stop_ev |=> !sda_oe);

  // R5: every register write is acknowledged
  a_r5_write_acked: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |=> sda_oe);

  // R7: writes never address beyond the bank
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |-> (int'(wr_idx) < NREG));

  // R8: power-down leaves the registers untouched
  a_r8_regs_kept: assert property (@(posedge clk) disable iff (!por_n)
    pwrdn |=> $stable(reg_bank));

  // R8: no acknowledge while powered down
  a_r8_no_ack: assert property (@(posedge clk) disable iff (!por_n)
    pwrdn |=> !sda_oe);
endmodule

bind smb_clkctl_slave smb_clkctl_slave_chk #(.NREG(NREG), .IDXW(IDXW)) u_chk (
  .clk(clk), .por_n(por_n), .pwrdn(pwrdn), .scl_f(scl_f), .sda_oe(sda_oe),
  .start_ev(start_ev), .stop_ev(stop_ev), .wr_en(wr_en), .wr_idx(wr_idx),
  .reg_bank(reg_bank));

// File: tb/smb_clkctl_slave_tb.sv
module smb_clkctl_slave_tb;
  localparam int NREG = 10;
  localparam int Q    = 12;   // quarter serial bit, in system cycles

  logic clk = 1'b0, ref_clk = 1'b0;
  logic por_n = 1'b0, pwrdn = 1'b0;
  logic scl = 1'b1, host_sda = 1'b1;
  logic sda_oe, sda_line;
  logic [7:0] clk_o;
  logic [NREG*8-1:0] reg_bank;
  time ref_time = 0;

  int nchk = 0, nfail = 0, glitches = 0;
  bit glitch_next = 1'b0;
  logic [7:0] exp_regs [NREG];
  logic [7:0] dbuf [16];

  assign sda_line = host_sda & ~sda_oe;

  smb_clkctl_slave u_dut (
    .clk(clk), .por_n(por_n), .pwrdn(pwrdn), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .ref_clk(ref_clk), .clk_o(clk_o), .reg_bank(reg_bank));

  always #4 clk = ~clk;
  always begin
    #5;
    ref_time = $time;
    ref_clk = ~ref_clk;
  end

  // R9: any change of a gated output away from a source edge is a glitch
  always @(clk_o) if ($time != ref_time) glitches++;

  function automatic logic [7:0] bench_default(input int i);
    return (i == 0) ? 8'hFF : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wq(Q);
    scl = 1'b1;      wq(Q);
    host_sda = 1'b0; wq(Q);
    scl = 1'b0;      wq(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(Q);
    scl = 1'b1;      wq(Q);
    host_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit got;
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i];
      if (glitch_next && i == 3) begin
        wq(2); scl = 1'b1; wq(2); scl = 1'b0; wq(Q - 4);
        glitch_next = 1'b0;
      end else begin
        wq(Q);
      end
      scl = 1'b1; wq(2*Q);
      scl = 1'b0; wq(Q);
    end
    host_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    got = ~sda_line;
    check(got == exp_ack, req, 64'(got), 64'(exp_ack));
    wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic check_regs(input string req);
    wq(4);
    for (int i = 0; i < NREG; i++)
      check(reg_bank[i*8 +: 8] == exp_regs[i], req, 64'(reg_bank[i*8 +: 8]), 64'(exp_regs[i]));
  endtask

  task automatic check_clk(input string req);
    logic [7:0] e;
    repeat (3) @(posedge ref_clk);
    #1;
    e = pwrdn ? 8'h00 : exp_regs[0];
    check(clk_o == e, req, 64'(clk_o), 64'(e));
  endtask

  // full transfer, expectations derived from the requirements
  task automatic xfer(input logic [7:0] addr, input int n, input bit do_stop);
    bit ok;
    ok = (addr == 8'hD2);
    bus_start();
    send_byte(addr, ok, "R3");
    send_byte(8'($urandom), ok, "R4");
    send_byte(8'($urandom), ok, "R4");
    for (int j = 0; j < n; j++) begin
      send_byte(dbuf[j], ok && j < NREG, (j < NREG) ? "R5" : "R7");
      if (ok && j < NREG) exp_regs[j] = dbuf[j];
    end
    if (do_stop) bus_stop();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NREG; i++) exp_regs[i] = bench_default(i);
    wq(5);
    por_n = 1'b1;
    wq(5);
    // R1: reset state
    check(sda_oe == 1'b0, "R1", 64'(sda_oe), 64'd0);
    check_regs("R1");
    check_clk("R1");

    // R5: full bank write, R9 with a mixed enable pattern
    for (int j = 0; j < 16; j++) dbuf[j] = 8'(8'h11 * j + 8'h05);
    dbuf[0] = 8'hA5;
    xfer(8'hD2, NREG, 1'b1);
    check_regs("R5");
    check_clk("R9");

    // R3: read request and foreign address are ignored
    for (int j = 0; j < 16; j++) dbuf[j] = 8'h3C;
    xfer(8'hD3, 3, 1'b1);
    check_regs("R3");
    xfer(8'hA2, 3, 1'b1);
    check_regs("R3");

    // R7: over-long transfer
    for (int j = 0; j < 16; j++) dbuf[j] = 8'(8'hC0 + j);
    xfer(8'hD2, 13, 1'b1);
    check_regs("R7");

    // R6: bytes after stop without a start get no acknowledge
    check(sda_oe == 1'b0, "R6", 64'(sda_oe), 64'd0);
    send_byte(8'hD2, 1'b0, "R6");
    bus_stop();
    check_regs("R6");

    // R2: repeated start right after an acknowledged data byte
    dbuf[0] = 8'h5A; dbuf[1] = 8'h77;
    xfer(8'hD2, 2, 1'b0);
    dbuf[0] = 8'h00;
    xfer(8'hD2, 1, 1'b1);
    check_regs("R2");
    check_clk("R9");

    // R8: power-down in the middle of a transfer
    bus_start();
    send_byte(8'hD2, 1'b1, "R3");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h81, 1'b1, "R5");
    exp_regs[0] = 8'h81;
    pwrdn = 1'b1;
    send_byte(8'h18, 1'b0, "R8");
    check_clk("R8");
    check_regs("R8");
    pwrdn = 1'b0;
    send_byte(8'h24, 1'b0, "R8");
    bus_stop();
    check_regs("R8");
    check_clk("R9");

    // R10: short glitch on the serial clock in a data byte
    for (int j = 0; j < 16; j++) dbuf[j] = 8'(8'h96 ^ j);
    glitch_next = 1'b1;
    xfer(8'hD2, 4, 1'b1);
    check_regs("R10");

    // constrained random transfers
    for (int t = 0; t < 10; t++) begin
      logic [7:0] a;
      int n;
      a = ($urandom_range(0, 9) < 7) ? 8'hD2 : 8'($urandom);
      n = $urandom_range(0, 12);
      for (int j = 0; j < 16; j++) dbuf[j] = 8'($urandom);
      xfer(a, n, 1'b1);
      check_regs("R5");
      check_clk("R9");
    end

    check(glitches == 0, "R9", 64'(glitches), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule